// File: doc/BRIEF.md
# Shadowed Video Clock Divider Bank

This block keeps seven small programmable dividers, one per video sub-function: the VGA output, the picture path, the TV encoder, the HDMI pixel path, the HDMI core, the display interface and the layer engine. All seven run from one common input clock. Each produces a one-cycle enable pulse whose spacing is set by a 3-bit ratio field. Downstream logic uses the pulse as a clock enable.

Software stages new ratios in shadow fields. The two shadow registers are a clock-select register, which holds the VGA and picture fields, and a divider-parameter register, which holds the other five. A shadow write never disturbs the running dividers. To commit a set of ratios, software first clears the update flag, then writes the fields it wants to change, then sets the flag. On the 0-to-1 transition of the flag, every divider loads its new ratio in the same clock cycle and restarts its count. All shadow fields are copied, including the ones that were not rewritten.

The control inputs are plain single-cycle strobes with no handshake. A strobe is accepted in every cycle in which it is high, so the block never applies back-pressure.

Top module: `vid_clkdiv_bank`

## Requirements
- R1: A live ratio field of value N makes that divider's tick output high for exactly one cycle in every N+1 cycles.
- R2: A field write selects its divider by identifier. The identifiers are 0 VGA, 1 picture, 2 TV encoder, 3 HDMI pixel, 4 HDMI, 5 interface and 6 layer, and tick_o bit k belongs to identifier k. Identifiers 0 and 1 are held in the clock-select shadow register and identifiers 2 to 6 in the divider-parameter shadow register.
- R3: A field write that carries identifier 7 changes no shadow field. This is observable after the next apply.
- R4: Writes to shadow fields leave the running ratios and tick outputs unchanged until an apply.
- R5: An apply happens only when upd_wr is high with upd_val 1 while the stored update flag is 0. Writing 1 when the flag is already 1 applies nothing.
- R6: On an apply, all seven dividers take their shadow ratios on the same clock edge and restart their counts. The first tick of a divider with ratio N follows N cycles after that edge, and there is no shortened period.
- R7: After reset, all shadow fields, all live ratios and the update flag are 0, so every tick output is high in every cycle (divide by one).
- R8: Writing 0 to the update flag clears it without changing any live ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common input clock for all dividers |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Strobe that writes one shadow ratio field |
| cfg_id | input | 3 | Divider identifier for the field write (0 to 6 valid, 7 ignored) |
| cfg_val | input | FIELD_W | Ratio value N; the divider divides by N+1 |
| upd_wr | input | 1 | Strobe that writes the update flag |
| upd_val | input | 1 | New update flag value; a 0-to-1 change applies the shadow ratios |
| tick_o | output | 7 | One divided enable per divider, indexed by identifier |

## Verification
A corrupted live ratio or counter appears at tick_o within one divider period. The pulse spacing of that divider then differs from N+1, so a fault is visible after at most eight cycles. A fault in the shadow bank or in the identifier decode stays hidden until the next apply. After that apply, the affected divider runs at the wrong rate, or two dividers swap rates. For that reason, each of the seven dividers is given a distinct ratio before the update. An apply that fires when it should not shows up immediately as a restart: every tick output is realigned on the cycle that follows the strobe.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int NUM_DIV    = 7;
  localparam int ID_W       = 3;
  localparam int SEL_FIELDS = 2;
  localparam int PAR_FIELDS = NUM_DIV - SEL_FIELDS;

  typedef enum logic [ID_W-1:0] {
    DIV_VGA      = 3'd0,
    DIV_PIC      = 3'd1,
    DIV_ENC_TV   = 3'd2,
    DIV_HDMI_PIX = 3'd3,
    DIV_HDMI     = 3'd4,
    DIV_INF      = 3'd5,
    DIV_LAYER    = 3'd6,
    DIV_NONE     = 3'd7
  } div_id_e;
endpackage

// File: rtl/clkdiv_shadow.sv
module clkdiv_shadow
  import clkdiv_pkg::*;
#(
  parameter int FW = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ID_W-1:0]       wr_id,
  input  logic [FW-1:0]         wr_val,
  output logic [NUM_DIV*FW-1:0] shadow_flat
);
  logic [SEL_FIELDS*FW-1:0] sel_reg;
  logic [PAR_FIELDS*FW-1:0] par_reg;

  // clock-select register: identifiers 0 .. SEL_FIELDS-1
  for (genvar g = 0; g < SEL_FIELDS; g++) begin : g_sel
    always_ff @(posedge clk) begin
      if (!rst_n)
        sel_reg[g*FW +: FW] <= '0;
      else if (wr_en && wr_id == ID_W'(g))
        sel_reg[g*FW +: FW] <= wr_val;
    end
  end

  // divider-parameter register: remaining identifiers; unknown ids match nothing
  for (genvar g = 0; g < PAR_FIELDS; g++) begin : g_par
    always_ff @(posedge clk) begin
      if (!rst_n)
        par_reg[g*FW +: FW] <= '0;
      else if (wr_en && wr_id == ID_W'(g + SEL_FIELDS))
        par_reg[g*FW +: FW] <= wr_val;
    end
  end

  assign shadow_flat = {par_reg, sel_reg};
endmodule

// File: rtl/clkdiv_update.sv
module clkdiv_update (
  input  logic clk,
  input  logic rst_n,
  input  logic upd_wr,
  input  logic upd_val,
  output logic flag_q,
  output logic apply
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      flag_q <= 1'b0;
    else if (upd_wr)
      flag_q <= upd_val;
  end

  // rising edge of the update flag commits the shadow bank
  assign apply = upd_wr & upd_val & ~flag_q;
endmodule

// File: rtl/clkdiv_cell.sv
module clkdiv_cell #(
  parameter int FW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          apply,
  input  logic [FW-1:0] new_ratio,
  output logic [FW-1:0] ratio_q,
  output logic          tick
);
  logic [FW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ratio_q <= '0;
      cnt_q   <= '0;
    end else if (apply) begin
      ratio_q <= new_ratio;
      cnt_q   <= '0;
    end else if (cnt_q == ratio_q) begin
      cnt_q   <= '0;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign tick = (cnt_q == ratio_q);
endmodule

// File: rtl/vid_clkdiv_bank.sv
module vid_clkdiv_bank
  import clkdiv_pkg::*;
#(
  parameter int FIELD_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [ID_W-1:0]    cfg_id,
  input  logic [FIELD_W-1:0] cfg_val,
  input  logic               upd_wr,
  input  logic               upd_val,
  output logic [NUM_DIV-1:0] tick_o
);
  logic [NUM_DIV*FIELD_W-1:0] shadow_flat;
  logic [NUM_DIV*FIELD_W-1:0] live_flat;
  logic                       apply;
  logic                       flag_q;

  clkdiv_shadow #(.FW(FIELD_W)) u_shadow (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (cfg_wr),
    .wr_id       (cfg_id),
    .wr_val      (cfg_val),
    .shadow_flat (shadow_flat)
  );

  clkdiv_update u_update (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_wr  (upd_wr),
    .upd_val (upd_val),
    .flag_q  (flag_q),
    .apply   (apply)
  );

  for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
    clkdiv_cell #(.FW(FIELD_W)) u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .apply     (apply),
      .new_ratio (shadow_flat[g*FIELD_W +: FIELD_W]),
      .ratio_q   (live_flat[g*FIELD_W +: FIELD_W]),
      .tick      (tick_o[g])
    );
  end
endmodule

// File: rtl/clkdiv_bank_chk.sv
module clkdiv_bank_chk
  import clkdiv_pkg::*;
#(
  parameter int FW = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  apply,
  input logic                  flag_q,
  input logic                  upd_wr,
  input logic                  upd_val,
  input logic [NUM_DIV*FW-1:0] live_flat,
  input logic [NUM_DIV-1:0]    tick_o
);
  AST_LIVE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> $stable(live_flat)); // R4

  AST_SET_TWICE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_wr && upd_val && flag_q) |=> $stable(live_flat)); // R5

  AST_CLEAR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_wr && !upd_val) |=> $stable(live_flat)); // R8

  for (genvar g = 0; g < NUM_DIV; g++) begin : g_chk
    AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      apply |=> (tick_o[g] == (live_flat[g*FW +: FW] == '0))); // R6

    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o[g] && live_flat[g*FW +: FW] != '0 && !apply) |=> !tick_o[g]); // R1

    AST_DIV_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (live_flat[g*FW +: FW] == '0) |-> tick_o[g]); // R7
  end
endmodule

bind vid_clkdiv_bank clkdiv_bank_chk #(.FW(FIELD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .apply     (apply),
  .flag_q    (flag_q),
  .upd_wr    (upd_wr),
  .upd_val   (upd_val),
  .live_flat (live_flat),
  .tick_o    (tick_o)
);

// File: tb/vid_clkdiv_bank_test.sv
`timescale 1ns/1ps
module vid_clkdiv_bank_test;
  localparam int ND = 7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [2:0] cfg_id = '0;
  logic [2:0] cfg_val = '0;
  logic       upd_wr = 1'b0;
  logic       upd_val = 1'b0;
  logic [ND-1:0] tick_o;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  logic [ND-1:0] exp_q[$];
  string         tag_q[$];

  int m_live[ND];
  int m_cnt[ND];
  int m_shadow[ND];
  bit m_flag;

  vid_clkdiv_bank uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_id(cfg_id),
    .cfg_val(cfg_val), .upd_wr(upd_wr), .upd_val(upd_val), .tick_o(tick_o)
  );

  always #2.5 clk = ~clk;

  // monitor: compares the state produced by each edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [ND-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      compared++;
      if (tick_o !== e) begin
        mismatched++;
        $display("FAIL %s tick_o actual %b expected %b at %0t", t, tick_o, e, $time);
      end
    end
  end

  // driver: applies one cycle of stimulus and pushes the expected result
  task automatic step(input bit wr, input int id, input int val,
                      input bit uw, input bit uv, input string tag);
    logic [ND-1:0] e;
    cfg_wr = wr; cfg_id = id[2:0]; cfg_val = val[2:0];
    upd_wr = uw; upd_val = uv;
    if (uw && uv && !m_flag) begin
      for (int i = 0; i < ND; i++) begin m_live[i] = m_shadow[i]; m_cnt[i] = 0; end
    end else begin
      for (int i = 0; i < ND; i++) m_cnt[i] = (m_cnt[i] == m_live[i]) ? 0 : m_cnt[i] + 1;
    end
    if (wr && id < ND) m_shadow[id] = val;   // R3: id 7 dropped
    if (uw) m_flag = uv;
    for (int i = 0; i < ND; i++) e[i] = (m_cnt[i] == m_live[i]);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    cfg_wr = 1'b0; upd_wr = 1'b0;
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    for (int i = 0; i < ND; i++) begin m_live[i] = 0; m_cnt[i] = 0; m_shadow[i] = 0; end
    m_flag = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(3, "R7");                              // reset: all divide by one
    for (int i = 0; i < ND; i++) step(1, i, i + 1, 0, 0, "R4");
    idle(4, "R4");                              // shadow writes not yet live
    step(1, 7, 5, 0, 0, "R3");                  // unknown id ignored
    step(0, 0, 0, 1, 1, "R6");                  // rising flag applies all
    idle(8, "R6");
    idle(60, "R2");                             // distinct periods per id
    step(1, 0, 0, 0, 0, "R4");
    step(0, 0, 0, 1, 1, "R5");                  // flag already set: no apply
    idle(20, "R5");
    step(0, 0, 0, 1, 0, "R8");                  // clear keeps ratios
    idle(10, "R8");
    step(1, 3, 0, 0, 0, "R4");
    step(1, 6, 2, 0, 0, "R4");
    step(1, 7, 1, 0, 0, "R3");
    step(0, 0, 0, 1, 1, "R6");
    idle(40, "R1");
    @(posedge clk); #2;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule